// File: doc/BRIEF.md
# Conditional Control-Transfer Unit

This block works out the next program counter for a small processor core's branch group: direct jumps, subroutine calls and returns, a jump through the H:L register pair, and fixed-vector restarts. Jumps, calls and returns can each be made conditional on one of eight flag tests. The same test table serves all three. When a test fails, execution falls through to the next sequential address. A call or restart that is taken saves the return address on a byte-wide stack. A return that is taken reloads the program counter from that stack.

A decoder pulses `start` for one cycle and provides the operation, the condition, the flags and the candidate addresses. The unit then runs its state machine. `ST_IDLE` either finishes the operation at once or moves to the push pair (`ST_PUSH_HI` then `ST_PUSH_LO`) or to the pop pair (`ST_POP_LO` then `ST_POP_HI`). Each of these states moves one stack byte and then steps to the next state. Both pairs return to `ST_IDLE`. In the cycle after the final edge, `done` pulses and `pc_out`/`taken` hold the result. The stack memory is read asynchronously: `mem_rdata` reflects `mem_addr` in the same cycle.

Top module: `branch_seq_unit`

## Requirements
- R1: Conditional operations (`cond_en`=1) test `cond_sel`. The encoding is 0: Z=0, 1: Z=1, 2: CY=0, 3: CY=1, 4: P=0, 5: P=1, 6: S=0, 7: S=1. The same table applies to jump, call and return.
- R2: A jump (`op`=0) that is unconditional (`cond_en`=0) or whose condition holds sets `pc_out` to `target` with `taken`=1. `done` pulses in the first cycle after the start edge, and there is no stack access.
- R3: The register jump (`op`=3) always loads `pc_out` = {`reg_h`,`reg_l`} in one cycle and ignores `cond_en`.
- R4: A call (`op`=1) whose condition holds writes next_seq[15:8] at SP−1 in the first busy cycle and next_seq[7:0] at SP−2 in the second. It then sets SP to SP−2 and `pc_out` to `target`. `done` pulses three cycles after the start edge.
- R5: A restart (`op`=4) always behaves like the call of R4, with target `rst_num`×8 (0x0000 to 0x0038).
- R6: A return (`op`=2) whose condition holds reads the low byte at SP and then the high byte at SP+1. It sets `pc_out` to the 16-bit value read and SP to SP+2, and `done` pulses three cycles after the start edge.
- R7: A conditional jump, call or return whose condition fails, and any operation code 5 to 7, completes with `done` in one cycle. `pc_out` = `next_seq`, `taken`=0, there is no memory write and SP is unchanged.
- R8: `busy` is high from the cycle after a push or pop starts until the last stack byte has moved. While `busy` is high, `start` and the other request inputs are ignored.
- R9: In reset, SP = SP_RESET (0x0000), and `busy`, `done`, `taken`, `mem_we` and `pc_out` are all 0.
- R10: SP changes only in steps of ±2, modulo 2^16. A call from SP=0x0000 writes at 0xFFFF and 0xFFFE and leaves SP=0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled in ST_IDLE |
| op | input | 3 | 0 jump, 1 call, 2 return, 3 H:L jump, 4 restart |
| cond_en | input | 1 | 1 = operation is conditional |
| cond_sel | input | 3 | Condition code (R1) |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag |
| flag_cy | input | 1 | Carry flag |
| target | input | 16 | Direct branch target |
| next_seq | input | 16 | Address of next sequential instruction |
| reg_h | input | 8 | H register |
| reg_l | input | 8 | L register |
| rst_num | input | 3 | Restart vector number |
| mem_rdata | input | 8 | Stack read data (combinational) |
| pc_out | output | 16 | Resulting program counter |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Transfer was taken |
| busy | output | 1 | Stack transfer in progress |
| sp | output | 16 | Stack pointer |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 8 | Stack write data |
| mem_we | output | 1 | Stack write enable |

## Verification
The hardest case to reach is a return that reads back exactly the bytes the bench has placed at the current SP, while SP itself keeps drifting as earlier calls and returns are taken or skipped. The bench keeps its own model of SP. Before each return it stores a known pair at the modelled SP and SP+1 in the memory it provides. It then sweeps every condition code against all sixteen flag combinations for jump, call and return. Holding `start` high with different inputs through a call covers the ignored-while-busy case.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
    localparam logic [2:0] OP_JUMP    = 3'd0;
    localparam logic [2:0] OP_CALL    = 3'd1;
    localparam logic [2:0] OP_RET     = 3'd2;
    localparam logic [2:0] OP_HLJMP   = 3'd3;
    localparam logic [2:0] OP_RESTART = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_HI = 3'd1,
        ST_PUSH_LO = 3'd2,
        ST_POP_LO  = 3'd3,
        ST_POP_HI  = 3'd4
    } ctu_state_e;
endpackage

// File: rtl/ctu_cond_eval.sv
module ctu_cond_eval (
    input  logic [2:0] cond_sel,
    input  logic       flag_s,
    input  logic       flag_z,
    input  logic       flag_p,
    input  logic       flag_cy,
    output logic       cond_true
);
    logic picked;

    // bits [2:1] pick the flag, bit 0 picks the polarity wanted
    always_comb begin
        unique case (cond_sel[2:1])
            2'd0:    picked = flag_z;
            2'd1:    picked = flag_cy;
            2'd2:    picked = flag_p;
            default: picked = flag_s;
        endcase
        cond_true = (picked == cond_sel[0]);
    end
endmodule

// File: rtl/ctu_dest_gen.sv
module ctu_dest_gen import ctu_pkg::*; #(
    parameter int ADDR_W    = 16,
    parameter int RST_SHIFT = 3
) (
    input  logic [2:0]          op,
    input  logic [ADDR_W-1:0]   target,
    input  logic [ADDR_W/2-1:0] reg_h,
    input  logic [ADDR_W/2-1:0] reg_l,
    input  logic [2:0]          rst_num,
    output logic [ADDR_W-1:0]   dest
);
    always_comb begin
        unique case (op)
            OP_HLJMP:   dest = {reg_h, reg_l};
            OP_RESTART: dest = ADDR_W'(rst_num) << RST_SHIFT;
            default:    dest = target;
        endcase
    end
endmodule

// File: rtl/ctu_stack_ptr.sv
module ctu_stack_ptr #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec2,
    input  logic              inc2,
    output logic [ADDR_W-1:0] sp
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sp <= SP_RESET;
        else if (dec2) sp <= sp - STEP;
        else if (inc2) sp <= sp + STEP;
    end

    AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rst_n) !(dec2 && inc2)); // R10
endmodule

// File: rtl/branch_seq_unit.sv
module branch_seq_unit import ctu_pkg::*; #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SP_RESET  = '0,
    parameter int                RST_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          op,
    input  logic                cond_en,
    input  logic [2:0]          cond_sel,
    input  logic                flag_s,
    input  logic                flag_z,
    input  logic                flag_p,
    input  logic                flag_cy,
    input  logic [ADDR_W-1:0]   target,
    input  logic [ADDR_W-1:0]   next_seq,
    input  logic [ADDR_W/2-1:0] reg_h,
    input  logic [ADDR_W/2-1:0] reg_l,
    input  logic [2:0]          rst_num,
    input  logic [ADDR_W/2-1:0] mem_rdata,
    output logic [ADDR_W-1:0]   pc_out,
    output logic                done,
    output logic                taken,
    output logic                busy,
    output logic [ADDR_W-1:0]   sp,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ADDR_W/2-1:0] mem_wdata,
    output logic                mem_we
);
    localparam int BYTE_W = ADDR_W / 2;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    ctu_state_e          state_q, state_d;
    logic                cond_true, cond_ok;
    logic                take, need_push, need_pop;
    logic [ADDR_W-1:0]   dest;
    logic [ADDR_W-1:0]   ret_q, dest_q;
    logic [BYTE_W-1:0]   lo_q;
    logic                sp_dec, sp_inc;

    ctu_cond_eval u_cond (
        .cond_sel (cond_sel),
        .flag_s   (flag_s),
        .flag_z   (flag_z),
        .flag_p   (flag_p),
        .flag_cy  (flag_cy),
        .cond_true(cond_true)
    );

    ctu_dest_gen #(.ADDR_W(ADDR_W), .RST_SHIFT(RST_SHIFT)) u_dest (
        .op     (op),
        .target (target),
        .reg_h  (reg_h),
        .reg_l  (reg_l),
        .rst_num(rst_num),
        .dest   (dest)
    );

    ctu_stack_ptr #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
        .clk  (clk),
        .rst_n(rst_n),
        .dec2 (sp_dec),
        .inc2 (sp_inc),
        .sp   (sp)
    );

    // request classification
    always_comb begin
        cond_ok   = !cond_en || cond_true;
        take      = 1'b0;
        need_push = 1'b0;
        need_pop  = 1'b0;
        unique case (op)
            OP_JUMP: take = cond_ok;
            OP_CALL: begin
                take      = cond_ok;
                need_push = cond_ok;
            end
            OP_RET: begin
                take     = cond_ok;
                need_pop = cond_ok;
            end
            OP_HLJMP: take = 1'b1;
            OP_RESTART: begin
                take      = 1'b1;
                need_push = 1'b1;
            end
            default: take = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && need_push)     state_d = ST_PUSH_HI;
                else if (start && need_pop) state_d = ST_POP_LO;
            end
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_IDLE;
            ST_POP_LO:  state_d = ST_POP_HI;
            ST_POP_HI:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_we    = 1'b0;
        mem_addr  = sp;
        mem_wdata = '0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        unique case (state_q)
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp - ONE;
                mem_wdata = ret_q[ADDR_W-1:BYTE_W];
            end
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = sp - TWO;
                mem_wdata = ret_q[BYTE_W-1:0];
                sp_dec    = 1'b1;
            end
            ST_POP_LO: mem_addr = sp;
            ST_POP_HI: begin
                mem_addr = sp + ONE;
                sp_inc   = 1'b1;
            end
            default: mem_addr = sp;
        endcase
    end

    // result and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_out <= '0;
            done   <= 1'b0;
            taken  <= 1'b0;
            ret_q  <= '0;
            dest_q <= '0;
            lo_q   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && need_push) begin
                        ret_q  <= next_seq;
                        dest_q <= dest;
                    end else if (start && !need_pop) begin
                        done   <= 1'b1;
                        taken  <= take;
                        pc_out <= take ? dest : next_seq;
                    end
                end
                ST_PUSH_LO: begin
                    done   <= 1'b1;
                    taken  <= 1'b1;
                    pc_out <= dest_q;
                end
                ST_POP_LO: lo_q <= mem_rdata;
                ST_POP_HI: begin
                    done   <= 1'b1;
                    taken  <= 1'b1;
                    pc_out <= {mem_rdata, lo_q};
                end
                default: ;
            endcase
        end
    end

    AST_SP_STEP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> (sp == $past(sp) - TWO || sp == $past(sp) + TWO)); // R10
    AST_NOTAKEN_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> ($stable(sp) && !$past(mem_we))); // R7
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R8
    AST_PUSH_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> (done && taken)); // R4
    AST_POP_RAISES_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state_q == ST_POP_HI)) |-> (sp == $past(sp) + TWO)); // R6
endmodule

// File: tb/branch_seq_unit_tb.sv
module branch_seq_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        cond_en = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic        flag_s = 1'b0, flag_z = 1'b0, flag_p = 1'b0, flag_cy = 1'b0;
    logic [15:0] target = '0, next_seq = '0;
    logic [7:0]  reg_h = '0, reg_l = '0;
    logic [2:0]  rst_num = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] pc_out, sp, mem_addr;
    logic        done, taken, busy, mem_we;
    logic [7:0]  mem_wdata;

    logic [7:0]  mem [0:255];
    int          wr_cnt = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    logic [15:0] sp_m = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    branch_seq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en),
        .cond_sel(cond_sel), .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p),
        .flag_cy(flag_cy), .target(target), .next_seq(next_seq), .reg_h(reg_h),
        .reg_l(reg_l), .rst_num(rst_num), .mem_rdata(mem_rdata), .pc_out(pc_out),
        .done(done), .taken(taken), .busy(busy), .sp(sp), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic cond_model(input logic [2:0] c, input logic [3:0] f);
        // f = {S, Z, P, CY}
        case (c)
            3'd0: return !f[2];
            3'd1: return f[2];
            3'd2: return !f[0];
            3'd3: return f[0];
            3'd4: return !f[1];
            3'd5: return f[1];
            3'd6: return !f[3];
            default: return f[3];
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic ce, input logic [2:0] cs,
                          input logic [3:0] f, input logic [15:0] tg, input logic [15:0] ns,
                          input logic [7:0] h, input logic [7:0] l, input logic [2:0] rn,
                          output int cyc, output int wrs);
        int base;
        @(negedge clk);
        op = o; cond_en = ce; cond_sel = cs;
        {flag_s, flag_z, flag_p, flag_cy} = f;
        target = tg; next_seq = ns; reg_h = h; reg_l = l; rst_num = rn;
        base = wr_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 12) begin
            @(negedge clk);
            cyc++;
        end
        wrs = wr_cnt - base;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc, wrs;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;

        // R9 reset state
        repeat (2) @(negedge clk);
        chk("R9", "sp", sp, 16'h0000);
        chk("R9", "busy", busy, 0);
        chk("R9", "done", done, 0);
        chk("R9", "taken", taken, 0);
        chk("R9", "mem_we", mem_we, 0);
        chk("R9", "pc_out", pc_out, 0);
        rst_n = 1'b1;

        // R10 wrap on first call from SP=0
        run_op(3'd1, 1'b0, 3'd0, 4'h0, 16'h1234, 16'hABCD, 8'h0, 8'h0, 3'd0, cyc, wrs);
        chk("R10", "sp after wrap", sp, 16'hFFFE);
        chk("R10", "hi at FFFF", mem[8'hFF], 8'hAB);
        chk("R10", "lo at FFFE", mem[8'hFE], 8'hCD);
        chk("R4", "pc", pc_out, 16'h1234);
        chk("R4", "cycles", cyc, 3);
        sp_m = 16'hFFFE;

        // R1 R2 R4 R6 R7 sweep: every condition x every flag set x jump/call/return
        for (int o = 0; o < 3; o++) begin
            for (int c = 0; c < 8; c++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [15:0] tg, ns, popv, exp_pc;
                    logic ok;
                    string rq;
                    tg   = 16'h4000 + 16'(o << 8) + 16'(c << 4) + 16'(f);
                    ns   = 16'h2000 + 16'(o << 8) + 16'(c << 4) + 16'(f);
                    popv = 16'h9000 + 16'(o << 8) + 16'(c << 4) + 16'(f);
                    if (o == 2) begin
                        mem[sp_m[7:0]]        = popv[7:0];
                        mem[8'(sp_m[7:0] + 1)] = popv[15:8];
                    end
                    ok = cond_model(3'(c), 4'(f));
                    rq = !ok ? "R7" : (o == 0 ? "R1 R2" : (o == 1 ? "R1 R4" : "R1 R6"));
                    run_op(3'(o), 1'b1, 3'(c), 4'(f), tg, ns, 8'h0, 8'h0, 3'd0, cyc, wrs);
                    exp_pc = !ok ? ns : (o == 2 ? popv : tg);
                    chk(rq, "pc", pc_out, exp_pc);
                    chk(rq, "taken", taken, ok);
                    chk(rq, "cycles", cyc, (ok && o != 0) ? 3 : 1);
                    chk(rq, "writes", wrs, (ok && o == 1) ? 2 : 0);
                    if (ok && o == 1) begin
                        chk(rq, "hi byte", mem[8'(sp_m[7:0] - 1)], ns[15:8]);
                        chk(rq, "lo byte", mem[8'(sp_m[7:0] - 2)], ns[7:0]);
                        sp_m = sp_m - 16'd2;
                    end else if (ok && o == 2) begin
                        sp_m = sp_m + 16'd2;
                    end
                    chk(rq, "sp", sp, sp_m);
                    chk(rq, "busy idle", busy, 0);
                end
            end
        end

        // R2 unconditional jump ignores failing flags
        run_op(3'd0, 1'b0, 3'd1, 4'h0, 16'hCAFE, 16'h0101, 8'h0, 8'h0, 3'd0, cyc, wrs);
        chk("R2", "pc", pc_out, 16'hCAFE);
        chk("R2", "cycles", cyc, 1);
        chk("R2", "writes", wrs, 0);

        // R3 register jump, cond_en ignored with failing condition
        run_op(3'd3, 1'b1, 3'd1, 4'h0, 16'h1111, 16'h2222, 8'h5A, 8'hC3, 3'd0, cyc, wrs);
        chk("R3", "pc", pc_out, 16'h5AC3);
        chk("R3", "taken", taken, 1);
        chk("R3", "cycles", cyc, 1);
        chk("R3", "sp", sp, sp_m);

        // R5 restart vectors
        for (int n = 0; n < 8; n++) begin
            logic [15:0] ns;
            ns = 16'h7700 + 16'(n);
            run_op(3'd4, 1'b1, 3'd1, 4'h0, 16'hFFFF, ns, 8'h0, 8'h0, 3'(n), cyc, wrs);
            chk("R5", "pc", pc_out, 16'(n * 8));
            chk("R5", "cycles", cyc, 3);
            chk("R5", "hi byte", mem[8'(sp_m[7:0] - 1)], ns[15:8]);
            chk("R5", "lo byte", mem[8'(sp_m[7:0] - 2)], ns[7:0]);
            sp_m = sp_m - 16'd2;
            chk("R5", "sp", sp, sp_m);
        end

        // R7 reserved op codes
        for (int o = 5; o < 8; o++) begin
            run_op(3'(o), 1'b0, 3'd0, 4'h0, 16'h3333, 16'h4444, 8'h0, 8'h0, 3'd0, cyc, wrs);
            chk("R7", "pc", pc_out, 16'h4444);
            chk("R7", "taken", taken, 0);
            chk("R7", "writes", wrs, 0);
            chk("R7", "sp", sp, sp_m);
        end

        // R8 start held with new inputs while busy
        @(negedge clk);
        op = 3'd1; cond_en = 1'b0; target = 16'h1357; next_seq = 16'h2468; start = 1'b1;
        @(negedge clk);
        chk("R8", "busy first", busy, 1);
        op = 3'd0; target = 16'hBEEF;
        @(negedge clk);
        chk("R8", "busy second", busy, 1);
        chk("R8", "done early", done, 0);
        @(negedge clk);
        start = 1'b0;
        chk("R8", "done", done, 1);
        chk("R8", "busy end", busy, 0);
        chk("R8", "pc", pc_out, 16'h1357);
        sp_m = sp_m - 16'd2;
        chk("R8", "sp", sp, sp_m);
        @(negedge clk);
        chk("R8", "no extra op", done, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule